// File: doc/BRIEF.md
# Memory Access Ordering Barrier Queue

This block sits between a processor's load/store unit and the memory bus. Each incoming request is a load, a store, a zero-line operation, a cache maintenance operation or a barrier. Each request carries four page attribute flags: write-through, caching-inhibited, coherence-required and guarded. It also carries a fault flag. Non-barrier requests are stored in an eight-entry queue. The queue sends them to the bus through a valid/ready handshake. A slot is released only when the bus returns a completion acknowledge that names the slot index.

Every request is sorted into one of three groups: ordering class A, ordering class B, or unordered. Class A holds guarded, caching-inhibited accesses and write-through stores. Class B holds coherent, cacheable, copy-back stores. Each class keeps its own epoch counter. A barrier request advances the counter of every class that has work in its current epoch. A queued request may go to the bus only when no entry of its class from an earlier epoch is still waiting for its acknowledge. Unordered traffic ignores epochs completely.

The block also holds a free-standing combinational decoder. The decoder reports whether a 32-bit instruction word is the barrier instruction.

Top module: `aoq_top`

## Requirements
- R1: Loads, stores and zero-lines to memory that is both caching-inhibited (ci=1) and guarded (gd=1) are class A. Stores and zero-lines with write-through set (wt=1) are also class A. A class-A entry behind a barrier is not offered on the bus until every class-A entry ahead of that barrier has been acknowledged.
- R2: Guarded/inhibited accesses and write-through stores share one class-A order. A write-through store behind a barrier waits for a guarded/inhibited store ahead of it.
- R3: Stores and zero-lines with ci=0, wt=0, mc=1 are class B and are ordered the same way. Loads to such memory are unordered and may be offered ahead of a blocked class-B store.
- R4: The two classes are ordered independently. A barrier that follows only class-A work does not hold back a later class-B store.
- R5: A zero-line request (op code 2) is classified and ordered exactly like a store (op code 1) with the same attributes.
- R6: A zero-line with fault=1 is unordered. It is not held behind a barrier. It does not count as earlier work that a barrier must wait for.
- R7: Cache maintenance requests (op code 3) are never ordered, whatever their attributes.
- R8: `dec_is_barrier` is 1 exactly when word bits [31:26]=31, bits [25:11]=0, bits [10:1]=854 and bit [0]=0. In the instruction's own numbering bit 0 is the most significant bit.
- R9: An entry keeps its slot after it is issued. It is freed in the cycle after its acknowledge (`ack_valid` with `ack_idx`).
- R10: A barrier (op code 4) that arrives while neither class has outstanding work is accepted in one cycle. It takes no slot, creates no bus traffic, and does not delay later accesses.
- R11: When all eight slots are occupied, `in_ready` is 0.
- R12: A new request goes into the lowest free slot. The bus is offered the lowest-indexed eligible, not-yet-issued slot, together with that slot's op code and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_op | input | 3 | 0 load, 1 store, 2 zero-line, 3 cache maintenance, 4 barrier |
| in_addr | input | AW | Request address |
| in_wt | input | 1 | Write-through required |
| in_ci | input | 1 | Caching inhibited |
| in_mc | input | 1 | Memory coherence required |
| in_gd | input | 1 | Guarded |
| in_fault | input | 1 | Request raised an alignment fault |
| bus_valid | output | 1 | An entry is offered to the bus |
| bus_ready | input | 1 | Bus takes the offered entry |
| bus_idx | output | IW | Slot index of the offered entry |
| bus_op | output | 3 | Op code of the offered entry |
| bus_addr | output | AW | Address of the offered entry |
| ack_valid | input | 1 | Completion acknowledge |
| ack_idx | input | IW | Slot being acknowledged |
| dec_word | input | 32 | Instruction word to decode |
| dec_is_barrier | output | 1 | Word is the barrier instruction |

## Verification
Several things can collide in one cycle. A bus issue and a bypass decision can coincide, and so can an acknowledge and an eligibility change. The bench provokes these by holding `bus_ready` low while it loads a barrier between two accesses of one class plus an unordered access. It then pulses issue and acknowledge one at a time. After each step it reads `bus_valid` and `bus_idx` half a cycle later. It judges that the unordered entry passes, the blocked entry stays hidden, and the blocked entry appears only after the acknowledge. A faulted zero-line placed on either side of a barrier checks that the class-bookkeeping path and the queue path agree on what counts as pending.

// File: rtl/aoq_pkg.sv
package aoq_pkg;

    typedef enum logic [2:0] {
        OP_LOAD    = 3'd0,
        OP_STORE   = 3'd1,
        OP_ZERO    = 3'd2,
        OP_CMAINT  = 3'd3,
        OP_BARRIER = 3'd4
    } aoq_op_e;

    typedef enum logic [1:0] {
        CLS_FREE = 2'd0,
        CLS_A    = 2'd1,
        CLS_B    = 2'd2
    } aoq_cls_e;

    typedef struct packed {
        logic wt;
        logic ci;
        logic mc;
        logic gd;
    } aoq_attr_t;

    localparam logic [5:0] BAR_PRIMARY = 6'd31;
    localparam logic [9:0] BAR_EXT     = 10'd854;

    // Sort one request into an ordering class.
    function automatic aoq_cls_e aoq_classify_f(logic [2:0] op, aoq_attr_t a, logic fault);
        logic store_like;
        logic guarded_io;
        store_like = (op == OP_STORE) || ((op == OP_ZERO) && !fault);
        guarded_io = a.ci && a.gd;
        if ((op == OP_LOAD) && guarded_io)
            return CLS_A;
        if (store_like && (guarded_io || a.wt))
            return CLS_A;
        if (store_like && !a.ci && !a.wt && a.mc)
            return CLS_B;
        return CLS_FREE;
    endfunction

    // Barrier instruction match, bit 31 of the vector is instruction bit 0.
    function automatic logic aoq_is_barrier_f(logic [31:0] w);
        return (w[31:26] == BAR_PRIMARY) && (w[25:11] == 15'd0) &&
               (w[10:1] == BAR_EXT) && !w[0];
    endfunction

endpackage

// File: rtl/aoq_classify.sv
module aoq_classify
    import aoq_pkg::*;
(
    input  logic [2:0] op,
    input  aoq_attr_t  attr,
    input  logic       fault,
    output aoq_cls_e   cls
);
    always_comb cls = aoq_classify_f(op, attr, fault);
endmodule

// File: rtl/aoq_decode.sv
module aoq_decode
    import aoq_pkg::*;
(
    input  logic [31:0] word,
    output logic        hit
);
    always_comb hit = aoq_is_barrier_f(word);
endmodule

// File: rtl/aoq_epoch.sv
module aoq_epoch #(
    parameter int EW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bump,
    input  logic          busy,
    output logic [EW-1:0] epoch
);
    always_ff @(posedge clk) begin
        if (rst)
            epoch <= '0;
        else if (bump && busy)
            epoch <= epoch + 1'b1;
    end

    // R10: a barrier with nothing pending in this class leaves its epoch alone
    p_idle_barrier_r10: assert property (@(posedge clk) disable iff (rst)
        (bump && !busy) |=> $stable(epoch));

    // R1: a barrier over pending work opens exactly one new epoch
    p_epoch_step_r1: assert property (@(posedge clk) disable iff (rst)
        (bump && busy) |=> (epoch == EW'($past(epoch) + 1'b1)));
endmodule

// File: rtl/aoq_top.sv
module aoq_top
    import aoq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [2:0]    in_op,
    input  logic [AW-1:0] in_addr,
    input  logic          in_wt,
    input  logic          in_ci,
    input  logic          in_mc,
    input  logic          in_gd,
    input  logic          in_fault,
    output logic          bus_valid,
    input  logic          bus_ready,
    output logic [IW-1:0] bus_idx,
    output logic [2:0]    bus_op,
    output logic [AW-1:0] bus_addr,
    input  logic          ack_valid,
    input  logic [IW-1:0] ack_idx,
    input  logic [31:0]   dec_word,
    output logic          dec_is_barrier
);
    localparam int EW     = IW + 2;   // live epochs span at most DEPTH
    localparam int NCLASS = 2;

    logic [DEPTH-1:0] ent_v;
    logic [DEPTH-1:0] ent_iss;
    aoq_cls_e         ent_cls  [DEPTH];
    logic [EW-1:0]    ent_ep   [DEPTH];
    logic [2:0]       ent_op   [DEPTH];
    logic [AW-1:0]    ent_addr [DEPTH];

    aoq_attr_t        in_attr;
    aoq_cls_e         in_cls;
    logic [IW-1:0]    alloc_idx;
    logic             wr_acc;
    logic             bar_acc;
    logic [EW-1:0]    new_ep;
    logic [NCLASS-1:0] cls_busy;
    logic [EW-1:0]    cls_ep [NCLASS];
    logic [DEPTH-1:0] elig;

    assign in_attr = '{wt: in_wt, ci: in_ci, mc: in_mc, gd: in_gd};

    aoq_classify u_cls (
        .op    (in_op),
        .attr  (in_attr),
        .fault (in_fault),
        .cls   (in_cls)
    );

    aoq_decode u_dec (
        .word (dec_word),
        .hit  (dec_is_barrier)
    );

    // Lowest free slot
    always_comb begin
        alloc_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (!ent_v[i]) alloc_idx = IW'(i);
    end

    assign in_ready = ~&ent_v;
    assign wr_acc   = in_valid && in_ready && (in_op != OP_BARRIER);
    assign bar_acc  = in_valid && in_ready && (in_op == OP_BARRIER);

    // A class is busy when some entry sits in its current epoch
    always_comb begin
        cls_busy = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_v[i] && ent_cls[i] == CLS_A && ent_ep[i] == cls_ep[0]) cls_busy[0] = 1'b1;
            if (ent_v[i] && ent_cls[i] == CLS_B && ent_ep[i] == cls_ep[1]) cls_busy[1] = 1'b1;
        end
    end

    for (genvar g = 0; g < NCLASS; g++) begin : g_cls
        aoq_epoch #(.EW(EW)) u_ep (
            .clk   (clk),
            .rst   (rst),
            .bump  (bar_acc),
            .busy  (cls_busy[g]),
            .epoch (cls_ep[g])
        );
    end

    always_comb begin
        case (in_cls)
            CLS_A:   new_ep = cls_ep[0];
            CLS_B:   new_ep = cls_ep[1];
            default: new_ep = '0;
        endcase
    end

    // Eligibility: no same-class entry from an older epoch still outstanding
    always_comb begin
        logic [EW-1:0] diff;
        elig = '0;
        for (int i = 0; i < DEPTH; i++) begin
            elig[i] = ent_v[i] && !ent_iss[i];
            for (int j = 0; j < DEPTH; j++) begin
                diff = ent_ep[i] - ent_ep[j];
                if (ent_v[j] && ent_cls[i] != CLS_FREE && ent_cls[j] == ent_cls[i] &&
                    diff != '0 && !diff[EW-1])
                    elig[i] = 1'b0;
            end
        end
    end

    always_comb begin
        bus_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (elig[i]) bus_idx = IW'(i);
    end

    assign bus_valid = |elig;
    assign bus_op    = ent_op[bus_idx];
    assign bus_addr  = ent_addr[bus_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_v   <= '0;
            ent_iss <= '0;
        end else begin
            if (wr_acc) begin
                ent_v[alloc_idx]   <= 1'b1;
                ent_iss[alloc_idx] <= 1'b0;
            end
            if (bus_valid && bus_ready)
                ent_iss[bus_idx] <= 1'b1;
            if (ack_valid)
                ent_v[ack_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_acc) begin
            ent_cls[alloc_idx]  <= in_cls;
            ent_ep[alloc_idx]   <= new_ep;
            ent_op[alloc_idx]   <= in_op;
            ent_addr[alloc_idx] <= in_addr;
        end
    end

    // R9: issuing an entry does not release its slot
    p_hold_after_issue_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready) |=> ent_v[$past(bus_idx)]);

    // R9: an acknowledge releases its slot
    p_ack_frees_r9: assert property (@(posedge clk) disable iff (rst)
        ack_valid |=> !ent_v[$past(ack_idx)]);

    // R9: acknowledges only name issued, occupied slots
    p_ack_legal_r9: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> (ent_v[ack_idx] && ent_iss[ack_idx]));

    // R12: the offered slot is occupied and not yet sent
    p_offer_fresh_r12: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> (ent_v[bus_idx] && !ent_iss[bus_idx]));

    // R11: a write never lands on an occupied slot
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        wr_acc |=> ent_v[$past(alloc_idx)] && !ent_iss[$past(alloc_idx)]);
endmodule

// File: tb/sim_aoq_top.sv
module sim_aoq_top;
    import aoq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid, in_ready;
    logic [2:0]    in_op;
    logic [AW-1:0] in_addr;
    logic          in_wt, in_ci, in_mc, in_gd, in_fault;
    logic          bus_valid, bus_ready;
    logic [IW-1:0] bus_idx;
    logic [2:0]    bus_op;
    logic [AW-1:0] bus_addr;
    logic          ack_valid;
    logic [IW-1:0] ack_idx;
    logic [31:0]   dec_word;
    logic          dec_is_barrier;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    aoq_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
        .in_addr(in_addr), .in_wt(in_wt), .in_ci(in_ci), .in_mc(in_mc), .in_gd(in_gd),
        .in_fault(in_fault), .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_idx(bus_idx),
        .bus_op(bus_op), .bus_addr(bus_addr), .ack_valid(ack_valid), .ack_idx(ack_idx),
        .dec_word(dec_word), .dec_is_barrier(dec_is_barrier)
    );

    // {word, expected match}
    localparam logic [32:0] DEC_VEC [8] = '{
        {32'h7C0006AC, 1'b1},
        {32'h7C0006AD, 1'b0},
        {32'h7C0006A8, 1'b0},
        {32'h7C2006AC, 1'b0},
        {32'h780006AC, 1'b0},
        {32'h7C000EAC, 1'b0},
        {32'h7C0004AC, 1'b0},
        {32'hFC0006AC, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_bus(input string req, input bit exp_v, input int exp_idx);
        chk(bus_valid == exp_v, {req, " bus_valid"}, int'(bus_valid), int'(exp_v));
        if (exp_v)
            chk(int'(bus_idx) == exp_idx, {req, " bus_idx"}, int'(bus_idx), exp_idx);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 0; bus_ready = 0; ack_valid = 0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input logic [2:0] op, input bit wt, input bit ci, input bit mc,
                        input bit gd, input bit fault, input logic [AW-1:0] addr);
        @(negedge clk);
        in_valid = 1; in_op = op; in_wt = wt; in_ci = ci; in_mc = mc; in_gd = gd;
        in_fault = fault; in_addr = addr;
        @(posedge clk);
        #1 in_valid = 0;
    endtask

    task automatic barrier();
        push(3'd4, 0, 0, 0, 0, 0, '0);
    endtask

    task automatic issue();
        @(negedge clk);
        bus_ready = 1;
        @(posedge clk);
        #1 bus_ready = 0;
    endtask

    task automatic ack(input int idx);
        @(negedge clk);
        ack_valid = 1; ack_idx = IW'(idx);
        @(posedge clk);
        #1 ack_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; in_valid = 0; in_op = '0; in_addr = '0; in_wt = 0; in_ci = 0; in_mc = 0;
        in_gd = 0; in_fault = 0; bus_ready = 0; ack_valid = 0; ack_idx = '0; dec_word = '0;

        // R8: decoder vectors
        for (int k = 0; k < 8; k++) begin
            dec_word = DEC_VEC[k][32:1];
            #1;
            chk(dec_is_barrier == DEC_VEC[k][0], "R8 decode", int'(dec_is_barrier), int'(DEC_VEC[k][0]));
        end

        // Reset state
        do_reset();
        chk(in_ready == 1'b1, "R11 reset in_ready", int'(in_ready), 1);
        chk(bus_valid == 1'b0, "R12 reset bus_valid", int'(bus_valid), 0);

        // R1 R2: guarded/inhibited store, barrier, write-through store
        push(3'd1, 0, 1, 0, 1, 0, 32'h100);
        barrier();
        push(3'd1, 1, 0, 0, 0, 0, 32'h104);
        @(negedge clk); chk_bus("R1 first offered", 1, 0);
        issue();
        @(negedge clk); chk_bus("R2 wt store waits", 0, 0);
        ack(0);
        @(negedge clk); chk_bus("R1 released after ack", 1, 1);
        chk(bus_addr == 32'h104, "R12 bus_addr", int'(bus_addr), 32'h104);

        // R3: class B ordering with load bypass
        do_reset();
        push(3'd1, 0, 0, 1, 0, 0, 32'h200);
        barrier();
        push(3'd1, 0, 0, 1, 0, 0, 32'h204);
        push(3'd0, 0, 0, 1, 0, 0, 32'h208);
        @(negedge clk); chk_bus("R3 first B store", 1, 0);
        issue();
        @(negedge clk); chk_bus("R3 load bypasses", 1, 2);
        chk(bus_op == 3'd0, "R12 bus_op load", int'(bus_op), 0);
        issue();
        @(negedge clk); chk_bus("R3 B store blocked", 0, 0);
        ack(0);
        @(negedge clk); chk_bus("R3 B store released", 1, 1);

        // R4: class independence
        do_reset();
        push(3'd1, 1, 0, 0, 0, 0, 32'h300);
        barrier();
        push(3'd1, 0, 0, 1, 0, 0, 32'h304);
        issue();
        @(negedge clk); chk_bus("R4 B store not held by A", 1, 1);

        // R5: zero-line ordered like a store
        do_reset();
        push(3'd2, 1, 0, 0, 0, 0, 32'h400);
        barrier();
        push(3'd1, 0, 1, 0, 1, 0, 32'h404);
        issue();
        @(negedge clk); chk_bus("R5 zero-line orders", 0, 0);

        // R6: faulted zero-line before barrier is not pending work
        do_reset();
        push(3'd2, 1, 0, 0, 0, 1, 32'h500);
        barrier();
        push(3'd1, 1, 0, 0, 0, 0, 32'h504);
        issue();
        @(negedge clk); chk_bus("R6 fault not counted", 1, 1);
        // R6: faulted zero-line after barrier is not held
        do_reset();
        push(3'd1, 1, 0, 0, 0, 0, 32'h510);
        barrier();
        push(3'd2, 1, 0, 0, 0, 1, 32'h514);
        issue();
        @(negedge clk); chk_bus("R6 fault not held", 1, 1);

        // R7: cache maintenance never ordered
        do_reset();
        push(3'd1, 1, 0, 0, 0, 0, 32'h600);
        barrier();
        push(3'd3, 1, 1, 0, 1, 0, 32'h604);
        issue();
        @(negedge clk); chk_bus("R7 maint bypasses", 1, 1);

        // R10: idle barrier
        do_reset();
        barrier();
        @(negedge clk);
        chk(in_ready == 1'b1, "R10 idle barrier ready", int'(in_ready), 1);
        chk_bus("R10 idle barrier no traffic", 0, 0);
        push(3'd1, 1, 0, 0, 0, 0, 32'h700);
        @(negedge clk); chk_bus("R10 store after idle barrier", 1, 0);

        // R11 R9 R12: fill, issue, ack
        do_reset();
        for (int k = 0; k < 8; k++) push(3'd1, 0, 0, 0, 0, 0, 32'h800 + 32'(4 * k));
        @(negedge clk);
        chk(in_ready == 1'b0, "R11 full", int'(in_ready), 0);
        chk_bus("R12 lowest offered", 1, 0);
        issue();
        @(negedge clk);
        chk(in_ready == 1'b0, "R9 issue keeps slot", int'(in_ready), 0);
        chk_bus("R12 next lowest", 1, 1);
        chk(bus_addr == 32'h804, "R12 addr slot1", int'(bus_addr), 32'h804);
        ack(0);
        @(negedge clk);
        chk(in_ready == 1'b1, "R9 ack frees", int'(in_ready), 1);
        push(3'd1, 0, 0, 0, 0, 0, 32'h900);
        @(negedge clk);
        chk(in_ready == 1'b0, "R12 refill lowest free", int'(in_ready), 0);
        chk_bus("R12 refilled slot0 offered", 1, 0);
        chk(bus_addr == 32'h900, "R12 refilled addr", int'(bus_addr), 32'h900);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule